// File: doc/BRIEF.md
# Self-Test Completion Snooper

This block sits beside the byte streams that carry commands to a security-module backend and the responses coming back from it. It does not buffer or forward any payload. It only watches each byte as it passes, decodes the fixed-size header at the front of every request and every response, and decides whether the command just answered was a continue-self-test command that completed without error.

Each request header is ten bytes long: a 2-byte tag, a 4-byte length and a 4-byte command ordinal. Each response header is also ten bytes long, and its last four bytes hold the return code. All multi-byte fields are big-endian. A request is classified as a self-test when its stream ends. The matching response is judged when its last byte arrives, and a success produces a single-cycle `selftest_done` pulse. The surrounding logic can use that pulse to set a sticky status flag.

Top module: `selftest_snoop`

## Requirements
- R1: A request counts as a self-test only when request bytes 6, 7, 8 and 9, read as a big-endian 32-bit value (byte 6 most significant), equal 0x00000053.
- R2: A request whose stream ends after fewer than 10 bytes is never a self-test. This holds even when the ordinal bytes it did carry would read as 0x53.
- R3: On success, `selftest_done` is high for exactly one cycle: the cycle right after the clock edge that accepts the last response byte.
- R4: A response whose stream ends after fewer than 10 bytes never produces `selftest_done`.
- R5: Response bytes 6 to 9, read big-endian, form the return code. A nonzero return code never produces `selftest_done`.
- R6: The first byte of a new request discards any pending self-test classification. A response that ends in the same cycle as that byte, or later, gives no pulse.
- R7: A response end consumes the pending classification, so one self-test request yields at most one pulse. A second response gives none.
- R8: While reset is asserted and after it is released, `selftest_done` is low and no classification is pending.
- R9: Cycles with a stream's valid low carry no byte and do not advance that stream's byte count.
- R10: Bytes past offset 9 in either stream do not change the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request byte is present this cycle |
| req_data | input | 8 | Request byte |
| req_last | input | 1 | Marks the final byte of a request |
| rsp_valid | input | 1 | A response byte is present this cycle |
| rsp_data | input | 8 | Response byte |
| rsp_last | input | 1 | Marks the final byte of a response |
| selftest_done | output | 1 | One-cycle pulse on a successful self-test |

## Verification
The only result, `selftest_done`, is registered. It is due in the cycle that follows the edge accepting the last response byte. The bench drives every byte on a falling edge and samples the pulse at the very next falling edge after the last response byte. It samples once more a cycle later to confirm the pulse lasted a single cycle. For cases where no pulse is expected, the same two sample points are used, so a late or stray pulse is also caught.

// File: rtl/stsn_pkg.sv
package stsn_pkg;
    localparam int BYTE_W      = 8;
    localparam int HDR_BYTES   = 10;
    localparam int FIELD_OFS   = 6;
    localparam int FIELD_BYTES = 4;
    localparam int FIELD_W     = FIELD_BYTES * BYTE_W;
    localparam logic [FIELD_W-1:0] SELFTEST_ORD = 32'h0000_0053;
endpackage

// File: rtl/stsn_hdr_field.sv
// Counts the bytes of one stream and gathers a big-endian header field.
// The outputs describe the state including the byte offered this cycle.
module stsn_hdr_field #(
    parameter int HDR_LEN     = stsn_pkg::HDR_BYTES,
    parameter int FIELD_OFS   = stsn_pkg::FIELD_OFS,
    parameter int FIELD_BYTES = stsn_pkg::FIELD_BYTES,
    parameter int BYTE_W      = stsn_pkg::BYTE_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          byte_valid,
    input  logic [BYTE_W-1:0]             byte_data,
    input  logic                          byte_last,
    output logic                          frame_start,
    output logic                          hdr_full,
    output logic [FIELD_BYTES*BYTE_W-1:0] field_val
);
    localparam int FW    = FIELD_BYTES * BYTE_W;
    localparam int CNT_W = $clog2(HDR_LEN + 1);
    localparam logic [CNT_W-1:0] LO_C  = CNT_W'(FIELD_OFS);
    localparam logic [CNT_W-1:0] HI_C  = CNT_W'(FIELD_OFS + FIELD_BYTES);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(HDR_LEN);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [FW-1:0]    field;
    } grab_st_t;

    grab_st_t s_d, s_q;
    logic [CNT_W-1:0] base_cnt_d, next_cnt_d;
    logic [FW-1:0]    base_field_d, shifted_d;

    always_comb begin
        s_d          = s_q;
        base_cnt_d   = s_q.busy ? s_q.cnt   : '0;
        base_field_d = s_q.busy ? s_q.field : '0;
        shifted_d    = base_field_d;
        if (base_cnt_d >= LO_C && base_cnt_d < HI_C) begin
            shifted_d = {base_field_d[FW-BYTE_W-1:0], byte_data};
        end
        next_cnt_d = (base_cnt_d == MAX_C) ? base_cnt_d : base_cnt_d + CNT_W'(1);
        if (byte_valid) begin
            s_d.busy  = !byte_last;
            s_d.cnt   = next_cnt_d;
            s_d.field = shifted_d;
        end
        frame_start = byte_valid && !s_q.busy;
        hdr_full    = (next_cnt_d == MAX_C);
        field_val   = shifted_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/stsn_verdict.sv
// Holds the pending self-test classification and forms the done pulse.
module stsn_verdict #(
    parameter int                        FIELD_W  = stsn_pkg::FIELD_W,
    parameter logic [FIELD_W-1:0]        TEST_ORD = stsn_pkg::SELFTEST_ORD
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_last,
    input  logic               req_start,
    input  logic               req_hdr_full,
    input  logic [FIELD_W-1:0] req_ord,
    input  logic               rsp_valid,
    input  logic               rsp_last,
    input  logic               rsp_hdr_full,
    input  logic [FIELD_W-1:0] rsp_code,
    output logic               done
);
    typedef struct packed {
        logic armed;
        logic done;
    } vd_st_t;

    vd_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (rsp_valid && rsp_last) begin
            st_d.done  = st_q.armed && !req_start && rsp_hdr_full && (rsp_code == '0);
            st_d.armed = 1'b0;
        end
        if (req_start) st_d.armed = 1'b0;
        if (req_valid && req_last) st_d.armed = req_hdr_full && (req_ord == TEST_ORD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;
endmodule

// File: rtl/selftest_snoop.sv
module selftest_snoop (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [7:0] req_data,
    input  logic       req_last,
    input  logic       rsp_valid,
    input  logic [7:0] rsp_data,
    input  logic       rsp_last,
    output logic       selftest_done
);
    import stsn_pkg::*;

    logic               req_start, req_hdr_full, rsp_start, rsp_hdr_full;
    logic [FIELD_W-1:0] req_ord, rsp_code;

    stsn_hdr_field u_req_hdr (
        .clk(clk), .rst_n(rst_n),
        .byte_valid(req_valid), .byte_data(req_data), .byte_last(req_last),
        .frame_start(req_start), .hdr_full(req_hdr_full), .field_val(req_ord)
    );

    stsn_hdr_field u_rsp_hdr (
        .clk(clk), .rst_n(rst_n),
        .byte_valid(rsp_valid), .byte_data(rsp_data), .byte_last(rsp_last),
        .frame_start(rsp_start), .hdr_full(rsp_hdr_full), .field_val(rsp_code)
    );

    stsn_verdict u_verdict (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_last(req_last), .req_start(req_start),
        .req_hdr_full(req_hdr_full), .req_ord(req_ord),
        .rsp_valid(rsp_valid), .rsp_last(rsp_last),
        .rsp_hdr_full(rsp_hdr_full), .rsp_code(rsp_code),
        .done(selftest_done)
    );

    logic unused_rsp_start;
    assign unused_rsp_start = rsp_start;
endmodule

// File: rtl/stsn_checker.sv
module stsn_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        rsp_valid,
    input logic        rsp_last,
    input logic        rsp_hdr_full,
    input logic [31:0] rsp_code,
    input logic        done
);
    // R3: a pulse follows the edge that took a final response byte
    a_r3_after_rsp_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rsp_valid && rsp_last));

    // R4: the response reached full header length
    a_r4_rsp_hdr_len: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rsp_hdr_full));

    // R5: the return code was zero
    a_r5_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(rsp_code) == 32'h0));

    // R6: no request byte alongside the final response byte of a success
    a_r6_no_req_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !$past(req_valid));
endmodule

bind selftest_snoop stsn_checker u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .rsp_valid(rsp_valid), .rsp_last(rsp_last),
    .rsp_hdr_full(rsp_hdr_full), .rsp_code(rsp_code),
    .done(selftest_done)
);

// File: tb/selftest_snoop_tb_top.sv
`timescale 1ns/1ps
module selftest_snoop_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_last = 1'b0, rsp_valid = 1'b0, rsp_last = 1'b0;
    logic [7:0] req_data = '0, rsp_data = '0;
    logic selftest_done;

    always #2.5 clk = ~clk;

    selftest_snoop dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_data(req_data), .req_last(req_last),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
        .selftest_done(selftest_done)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    logic [7:0] rq [0:31];
    logic [7:0] rs [0:31];
    int rq_len = 0, rs_len = 0;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got cycle %0d expected below 100000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    function automatic logic model();
        logic ok_req, ok_rsp;
        ok_req = (rq_len >= 10) && ({rq[6], rq[7], rq[8], rq[9]} == 32'h53);
        ok_rsp = (rs_len >= 10) && ({rs[6], rs[7], rs[8], rs[9]} == 32'h0);
        return ok_req && ok_rsp;
    endfunction

    task automatic build_req(input int len, input bit st);
        for (int i = 0; i < 32; i++) rq[i] = 8'($urandom);
        if (st) begin rq[6] = 8'h00; rq[7] = 8'h00; rq[8] = 8'h00; rq[9] = 8'h53; end
        rq_len = len;
    endtask

    task automatic build_rsp(input int len, input bit ok);
        for (int i = 0; i < 32; i++) rs[i] = 8'($urandom);
        if (ok) begin rs[6] = 8'h00; rs[7] = 8'h00; rs[8] = 8'h00; rs[9] = 8'h00; end
        rs_len = len;
    endtask

    // drives bytes on falling edges; returns at the falling edge after the last byte
    task automatic send(input bit is_req, input bit gaps, input int inj);
        int len;
        len = is_req ? rq_len : rs_len;
        for (int i = 0; i < len; i++) begin
            if (gaps) while ($urandom_range(0, 3) == 0) @(negedge clk);
            if (is_req) begin
                req_valid = 1'b1; req_data = rq[i]; req_last = (i == len - 1);
            end else begin
                rsp_valid = 1'b1; rsp_data = rs[i]; rsp_last = (i == len - 1);
                if (i == inj) begin req_valid = 1'b1; req_data = 8'h00; req_last = 1'b1; end
            end
            @(negedge clk);
            req_valid = 1'b0; req_last = 1'b0; rsp_valid = 1'b0; rsp_last = 1'b0;
        end
    endtask

    task automatic pair(input string tag, input bit gaps, input int inj, input logic exp);
        send(1'b1, gaps, -1);
        repeat ($urandom_range(0, 2)) @(negedge clk);
        send(1'b0, gaps, inj);
        check(tag, selftest_done, exp);
        @(negedge clk);
        check({tag, " (R3 single cycle)"}, selftest_done, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R8 done low in reset", selftest_done, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: response straight after reset, nothing pending
        build_rsp(10, 1'b1); send(1'b0, 1'b0, -1);
        check("R8 no pending after reset", selftest_done, 1'b0);

        build_req(10, 1'b1); build_rsp(10, 1'b1);
        pair("R1 self-test success", 1'b0, -1, 1'b1);
        // R7: a second response gives no pulse
        build_rsp(10, 1'b1); send(1'b0, 1'b0, -1);
        check("R7 consumed", selftest_done, 1'b0);

        build_req(10, 1'b1); rq[9] = 8'h54; build_rsp(10, 1'b1);
        pair("R1 other ordinal", 1'b0, -1, 1'b0);
        build_req(10, 1'b1); rq[6] = 8'h53; rq[9] = 8'h00; build_rsp(10, 1'b1);
        pair("R1 byte order", 1'b0, -1, 1'b0);
        build_req(9, 1'b0); rq[6] = 8'h00; rq[7] = 8'h00; rq[8] = 8'h53; build_rsp(10, 1'b1);
        pair("R2 short request", 1'b0, -1, 1'b0);
        build_req(10, 1'b1); build_rsp(9, 1'b1);
        pair("R4 short response", 1'b0, -1, 1'b0);
        build_req(10, 1'b1); build_rsp(10, 1'b1); rs[8] = 8'h01;
        pair("R5 nonzero code", 1'b0, -1, 1'b0);
        build_req(20, 1'b1); build_rsp(25, 1'b1);
        pair("R10 long frames", 1'b0, -1, 1'b1);
        build_req(12, 1'b1); build_rsp(14, 1'b1);
        pair("R9 idle gaps", 1'b1, -1, 1'b1);
        build_req(10, 1'b1); build_rsp(12, 1'b1);
        pair("R6 new request mid-response", 1'b0, 4, 1'b0);
        build_req(10, 1'b1); build_rsp(12, 1'b1);
        pair("R6 new request on last byte", 1'b0, 11, 1'b0);

        // R8: reset discards a pending classification
        build_req(10, 1'b1); send(1'b1, 1'b0, -1);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        build_rsp(10, 1'b1); send(1'b0, 1'b0, -1);
        check("R8 reset clears pending", selftest_done, 1'b0);

        for (int k = 0; k < 60; k++) begin
            logic e;
            build_req($urandom_range(6, 20), $urandom_range(0, 1) == 1);
            build_rsp($urandom_range(6, 20), $urandom_range(0, 1) == 1);
            e = model();
            pair("R1/R4/R5/R9 random", $urandom_range(0, 1) == 1, -1, e);
        end

        summary();
        $finish;
    end
endmodule